// File: doc/BRIEF.md
# Two-Wire Slave Front End for a Wiper Register File

This block is the serial control port of a multi-channel digital potentiometer. It oversamples the bus clock and data lines with the system clock and finds start and stop conditions. It frames bytes, answers its own 7-bit address, and decodes one instruction byte. That instruction either writes a byte into the wiper bank or into the nonvolatile-shadow bank, or it raises a one-cycle command strobe for the command logic that sits beside the block. A read that carries no instruction byte streams the wiper values back, starting at wiper 0.

The bus data line is open-drain. The block never drives it high: `sda_oe_o` high means "pull the line low". The command strobe is a plain pulse with no back-pressure, so the consumer must take opcode and target in the cycle that `cmd_valid_o` is high. The register contents are presented continuously as flat vectors, with entry i in bits [8i+7:8i].

Top module: `i2c_wiper_slave`

## Requirements
- R1: After reset the block releases the data line, keeps `cmd_valid_o` low, holds every wiper at 0x80 and every shadow entry at 0x00.
- R2: The device address is 0b01011 followed by `strap_i[1]` and `strap_i[0]`, and bit 0 of the first byte is the direction (1 = read). The block pulls SDA low for the ninth bit only when the seven address bits match.
- R3: On an address mismatch the block acknowledges nothing and changes no register until the next start condition.
- R4: SDA falling while SCL is high (start) restarts framing at the address byte, even in the middle of a byte. SDA rising while SCL is high (stop) releases the line and ends the transfer, and a transfer stopped before its data byte writes nothing.
- R5: In a write, the byte after the address is the instruction and the byte after that is the data. All bytes are sent MSB first and the block acknowledges each of them. When instruction bit 7 = 0 and bit 5 = 0, the wiper at address bits [4:0] takes the data byte once that byte's acknowledge bit ends.
- R6: When instruction bit 7 = 0 and bit 5 = 1, the data goes to the shadow entry at bits [4:0], and the wipers stay unchanged.
- R7: A register address at or beyond the size of the selected bank is still acknowledged but changes no register.
- R8: When instruction bit 7 = 1, the data byte is acknowledged and, at the end of its acknowledge bit, `cmd_valid_o` pulses for one cycle. The pulse carries the opcode from bits [6:3] and the target from bits [2:0]. It happens only for targets 3'b001 and 3'b011, and no register changes.
- R9: A read returns wiper 0 first, MSB first. The block changes SDA only while SCL is low.
- R10: Each master acknowledge (SDA low on the ninth bit) moves the read to the next wiper. After the last wiper the read wraps to wiper 0.
- R11: A master no-acknowledge ends the read. The block then leaves SDA released until the next start.
- R12: Further data bytes in the same write are acknowledged and repeat the action on the same target, so the last byte wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| strap_i | input | 2 | Low two address bits from strap pins |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_opcode_o | output | 4 | Command opcode, valid with the strobe |
| cmd_addr_o | output | 3 | Command target wiper, valid with the strobe |
| wiper_flat_o | output | WIPERS*8 | All wiper values, flattened |
| shadow_flat_o | output | SHADOWS*8 | All shadow values, flattened |

## Verification
A wrong framing state shows up within one byte. Either the acknowledge bit goes missing or appears on a foreign address, or a data byte lands in the wrong bank or at the wrong index; this shows on the register vectors as soon as the bus goes quiet. A stale read pointer shows up in the very next byte read back, because the reference predicts every wiper and the wrap point. A bad command decode shows up as a missing, extra or mislabeled strobe when the strobes seen are compared with those predicted after each transfer.

// File: rtl/i2cw_pkg.sv
`timescale 1ns/1ps
package i2cw_pkg;
  localparam logic [4:0] ADDR_PREFIX = 5'b01011;
  localparam int IB_MODE = 7;
  localparam int IB_BANK = 5;
  localparam logic [2:0] CMD_TGT_A = 3'b001;
  localparam logic [2:0] CMD_TGT_B = 3'b011;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_NEXT
  } bus_state_t;

  typedef enum logic [1:0] {
    BK_ADDR, BK_INSTR, BK_DATA
  } byte_kind_t;
endpackage

// File: rtl/i2cw_line_sync.sv
`timescale 1ns/1ps
module i2cw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], line_i};
  end

  assign level_o = chain[STAGES-1];
  assign rise_o  = chain[STAGES-1] & ~chain[STAGES];
  assign fall_o  = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/i2cw_regfile.sv
`timescale 1ns/1ps
module i2cw_regfile #(
  parameter int WIPERS = 4,
  parameter int SHADOWS = 8,
  parameter int WIDX = 2,
  parameter logic [7:0] WIPER_INIT = 8'h80
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   wr_shadow,
  input  logic [4:0]             wr_addr,
  input  logic [7:0]             wr_data,
  input  logic [WIDX-1:0]        rd_idx,
  output logic [7:0]             rd_data,
  output logic [WIPERS*8-1:0]    wiper_flat,
  output logic [SHADOWS*8-1:0]   shadow_flat
);
  for (genvar i = 0; i < WIPERS; i++) begin : g_wiper
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= WIPER_INIT;
      else if (wr_en && !wr_shadow && wr_addr == 5'(i)) q <= wr_data;
    end
    assign wiper_flat[i*8 +: 8] = q;
  end

  for (genvar i = 0; i < SHADOWS; i++) begin : g_shadow
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (wr_en && wr_shadow && wr_addr == 5'(i)) q <= wr_data;
    end
    assign shadow_flat[i*8 +: 8] = q;
  end

  assign rd_data = wiper_flat[{rd_idx, 3'b000} +: 8];
endmodule

// File: rtl/i2cw_bus_fsm.sv
`timescale 1ns/1ps
module i2cw_bus_fsm
  import i2cw_pkg::*;
#(
  parameter int WIPERS = 4,
  parameter int WIDX = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_lvl,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            sda_lvl,
  input  logic            sda_rise,
  input  logic            sda_fall,
  input  logic [1:0]      strap,
  input  logic [7:0]      rd_data,
  output logic            sda_oe,
  output logic [WIDX-1:0] rd_idx,
  output logic            wr_en,
  output logic            wr_shadow,
  output logic [4:0]      wr_addr,
  output logic [7:0]      wr_data,
  output logic            cmd_valid,
  output logic [3:0]      cmd_opcode,
  output logic [2:0]      cmd_addr
);
  bus_state_t state;
  byte_kind_t kind;
  logic [3:0] bit_cnt;
  logic [7:0] sh;
  logic [7:0] instr;
  logic start_det, stop_det, addr_hit, tgt_ok;

  assign start_det = scl_lvl & sda_fall;
  assign stop_det  = scl_lvl & sda_rise;
  assign addr_hit  = (sh[7:1] == {ADDR_PREFIX, strap});
  assign tgt_ok    = (instr[2:0] == CMD_TGT_A) || (instr[2:0] == CMD_TGT_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      kind       <= BK_ADDR;
      bit_cnt    <= '0;
      sh         <= '0;
      instr      <= '0;
      sda_oe     <= 1'b0;
      rd_idx     <= '0;
      wr_en      <= 1'b0;
      wr_shadow  <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      cmd_valid  <= 1'b0;
      cmd_opcode <= '0;
      cmd_addr   <= '0;
    end else begin
      wr_en     <= 1'b0;
      cmd_valid <= 1'b0;
      if (start_det) begin
        state   <= ST_RX;
        kind    <= BK_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise) begin
              sh      <= {sh[6:0], sda_lvl};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              if (kind == BK_ADDR && !addr_hit) begin
                state <= ST_IDLE;
              end else begin
                state  <= ST_ACK;
                sda_oe <= 1'b1;
                if (kind == BK_ADDR) rd_idx <= '0;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              case (kind)
                BK_ADDR: begin
                  if (sh[0]) begin
                    sh      <= rd_data;
                    sda_oe  <= ~rd_data[7];
                    bit_cnt <= '0;
                    state   <= ST_TX;
                  end else begin
                    kind  <= BK_INSTR;
                    state <= ST_RX;
                  end
                end
                BK_INSTR: begin
                  instr <= sh;
                  kind  <= BK_DATA;
                  state <= ST_RX;
                end
                default: begin
                  state <= ST_RX;
                  if (instr[IB_MODE]) begin
                    if (tgt_ok) begin
                      cmd_valid  <= 1'b1;
                      cmd_opcode <= instr[6:3];
                      cmd_addr   <= instr[2:0];
                    end
                  end else begin
                    wr_en     <= 1'b1;
                    wr_shadow <= instr[IB_BANK];
                    wr_addr   <= instr[4:0];
                    wr_data   <= sh;
                  end
                end
              endcase
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd7) begin
                sda_oe <= 1'b0;
                state  <= ST_MACK;
              end else begin
                sh      <= {sh[6:0], 1'b0};
                sda_oe  <= ~sh[6];
                bit_cnt <= bit_cnt + 4'd1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              if (sda_lvl) begin
                state <= ST_IDLE;
              end else begin
                rd_idx <= (rd_idx == WIDX'(WIPERS-1)) ? '0 : rd_idx + 1'b1;
                state  <= ST_NEXT;
              end
            end
          end
          ST_NEXT: begin
            if (scl_fall) begin
              sh      <= rd_data;
              sda_oe  <= ~rd_data[7];
              bit_cnt <= '0;
              state   <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_wiper_slave.sv
`timescale 1ns/1ps
module i2c_wiper_slave #(
  parameter int WIPERS = 4,
  parameter int SHADOWS = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] WIPER_INIT = 8'h80
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic [1:0]           strap_i,
  output logic                 sda_oe_o,
  output logic                 cmd_valid_o,
  output logic [3:0]           cmd_opcode_o,
  output logic [2:0]           cmd_addr_o,
  output logic [WIPERS*8-1:0]  wiper_flat_o,
  output logic [SHADOWS*8-1:0] shadow_flat_o
);
  localparam int WIDX = (WIPERS > 1) ? $clog2(WIPERS) : 1;

  logic [1:0] line_in, line_lvl, line_rise, line_fall;
  logic scl_lvl;
  logic [WIDX-1:0] rd_idx;
  logic [7:0] rd_data, wr_data;
  logic [4:0] wr_addr;
  logic wr_en, wr_shadow;

  assign line_in = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    i2cw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_i  (line_in[g]),
      .level_o (line_lvl[g]),
      .rise_o  (line_rise[g]),
      .fall_o  (line_fall[g])
    );
  end

  assign scl_lvl = line_lvl[0];

  i2cw_bus_fsm #(.WIPERS(WIPERS), .WIDX(WIDX)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_lvl    (scl_lvl),
    .scl_rise   (line_rise[0]),
    .scl_fall   (line_fall[0]),
    .sda_lvl    (line_lvl[1]),
    .sda_rise   (line_rise[1]),
    .sda_fall   (line_fall[1]),
    .strap      (strap_i),
    .rd_data    (rd_data),
    .sda_oe     (sda_oe_o),
    .rd_idx     (rd_idx),
    .wr_en      (wr_en),
    .wr_shadow  (wr_shadow),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .cmd_valid  (cmd_valid_o),
    .cmd_opcode (cmd_opcode_o),
    .cmd_addr   (cmd_addr_o)
  );

  i2cw_regfile #(
    .WIPERS(WIPERS), .SHADOWS(SHADOWS), .WIDX(WIDX), .WIPER_INIT(WIPER_INIT)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_shadow   (wr_shadow),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_idx      (rd_idx),
    .rd_data     (rd_data),
    .wiper_flat  (wiper_flat_o),
    .shadow_flat (shadow_flat_o)
  );
endmodule

// File: rtl/i2cw_checker.sv
`timescale 1ns/1ps
module i2cw_checker #(
  parameter int WIPERS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                scl_lvl,
  input logic                sda_oe,
  input logic                cmd_valid,
  input logic [2:0]          cmd_addr,
  input logic [WIPERS*8-1:0] wiper_flat
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!sda_oe && !cmd_valid));

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  assert_strobe_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_addr == 3'b001 || cmd_addr == 3'b011));

  assert_strobe_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $stable(wiper_flat));

  assert_sda_moves_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_lvl);
endmodule

bind i2c_wiper_slave i2cw_checker #(.WIPERS(WIPERS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_lvl    (scl_lvl),
  .sda_oe     (sda_oe_o),
  .cmd_valid  (cmd_valid_o),
  .cmd_addr   (cmd_addr_o),
  .wiper_flat (wiper_flat_o)
);

// File: tb/i2c_wiper_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_wiper_slave_tb_top;
  localparam int WIPERS = 4;
  localparam int SHADOWS = 8;
  localparam time QT = 20ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sda_oe, cmd_valid;
  logic [3:0] cmd_opcode;
  logic [2:0] cmd_addr;
  logic [WIPERS*8-1:0] wiper_flat;
  logic [SHADOWS*8-1:0] shadow_flat;
  logic sda_bus;

  always #2.5 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_wiper_slave #(.WIPERS(WIPERS), .SHADOWS(SHADOWS)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .strap_i(strap),
    .sda_oe_o(sda_oe), .cmd_valid_o(cmd_valid), .cmd_opcode_o(cmd_opcode),
    .cmd_addr_o(cmd_addr), .wiper_flat_o(wiper_flat), .shadow_flat_o(shadow_flat)
  );

  int vectors = 0;
  int miscompares = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;
  logic [7:0] exp_w [WIPERS];
  logic [7:0] exp_s [SHADOWS];
  logic [6:0] exp_cmd_q [$];
  logic [6:0] got_cmd_q [$];

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] flat_w();
    logic [63:0] v = '0;
    for (int i = 0; i < WIPERS; i++) v[i*8 +: 8] = exp_w[i];
    return v;
  endfunction

  function automatic logic [63:0] flat_s();
    logic [63:0] v = '0;
    for (int i = 0; i < SHADOWS; i++) v[i*8 +: 8] = exp_s[i];
    return v;
  endfunction

  // reference model of one accepted write transfer
  function automatic void model_write(input logic [7:0] ins, input logic [7:0] dat);
    if (ins[7]) begin
      if (ins[2:0] == 3'd1 || ins[2:0] == 3'd3) exp_cmd_q.push_back({ins[6:3], ins[2:0]});
    end else if (ins[5]) begin
      if (int'(ins[4:0]) < SHADOWS) exp_s[ins[4:0]] = dat;
    end else begin
      if (int'(ins[4:0]) < WIPERS) exp_w[ins[4:0]] = dat;
    end
  endfunction

  // per-clock comparison while the bus is quiet
  always @(negedge clk) begin
    if (cmd_valid) got_cmd_q.push_back({cmd_opcode, cmd_addr});
    if (cmp_en) begin
      check("R5", "wipers", 64'(wiper_flat), flat_w());
      check("R6", "shadows", 64'(shadow_flat), flat_s());
      check("R4", "sda_oe quiet", 64'(sda_oe), 64'd0);
      check("R8", "strobe quiet", 64'(cmd_valid), 64'd0);
    end
  end

  task automatic bit_xfer(input logic b, output logic r);
    m_sda = b; #QT; m_scl = 1'b1; #QT; r = sda_bus; #QT; m_scl = 1'b0; #QT;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; #QT; m_scl = 1'b1; #QT; m_sda = 1'b0; #QT; m_scl = 1'b0; #QT;
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; #QT; m_scl = 1'b1; #QT; m_sda = 1'b1; #QT; #QT;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], r);
    bit_xfer(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, r);
      b[i] = r;
    end
    bit_xfer(~mack, r);
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    cmp_en = 1'b1;
  endtask

  task automatic wr_txn(input logic [6:0] a7, input logic [7:0] ins, input logic [7:0] dat,
                        input logic exp_ack, input string req);
    logic ack;
    cmp_en = 1'b0;
    bus_start();
    send_byte({a7, 1'b0}, ack); check(req, "address ack", 64'(ack), 64'(exp_ack));
    send_byte(ins, ack);        check(req, "instr ack", 64'(ack), 64'(exp_ack));
    send_byte(dat, ack);        check(req, "data ack", 64'(ack), 64'(exp_ack));
    bus_stop();
    if (exp_ack) model_write(ins, dat);
    settle();
  endtask

  task automatic cmd_compare(input string req);
    check(req, "strobe count", 64'(got_cmd_q.size()), 64'(exp_cmd_q.size()));
    while (exp_cmd_q.size() > 0 && got_cmd_q.size() > 0)
      check(req, "strobe op/target", 64'(got_cmd_q.pop_front()), 64'(exp_cmd_q.pop_front()));
    exp_cmd_q.delete();
    got_cmd_q.delete();
  endtask

  initial begin
    #600us;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic ack, r;
    logic [7:0] b;
    for (int i = 0; i < WIPERS; i++) exp_w[i] = 8'h80;
    for (int i = 0; i < SHADOWS; i++) exp_s[i] = 8'h00;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R1", "sda_oe in reset", 64'(sda_oe), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "reset wipers", 64'(wiper_flat), 64'h80808080);
    check("R1", "reset shadows", 64'(shadow_flat), 64'd0);
    check("R1", "reset strobe", 64'(cmd_valid), 64'd0);
    settle();

    // strap 10 -> address 0101110
    wr_txn(7'h2E, 8'h02, 8'h3C, 1'b1, "R5");
    wr_txn(7'h2E, 8'h25, 8'hA5, 1'b1, "R6");
    wr_txn(7'h2E, 8'h1F, 8'h11, 1'b1, "R7");
    wr_txn(7'h2E, 8'h3F, 8'h22, 1'b1, "R7");
    wr_txn(7'h2C, 8'h02, 8'h77, 1'b0, "R3");
    check("R3", "wiper2 after foreign write", 64'(wiper_flat[23:16]), 64'h3C);

    strap = 2'b01;
    repeat (4) @(posedge clk);
    wr_txn(7'h2D, 8'h01, 8'h99, 1'b1, "R2");
    wr_txn(7'h2E, 8'h01, 8'h55, 1'b0, "R2");

    wr_txn(7'h2D, 8'hD3, 8'h00, 1'b1, "R8");
    wr_txn(7'h2D, 8'hB9, 8'h5A, 1'b1, "R8");
    wr_txn(7'h2D, 8'h8A, 8'h00, 1'b1, "R8");
    cmd_compare("R8");

    // streaming read with wrap, then no-acknowledge
    cmp_en = 1'b0;
    bus_start();
    send_byte(8'h5B, ack); check("R2", "read address ack", 64'(ack), 64'd1);
    for (int k = 0; k < 6; k++) begin
      recv_byte(k < 5, b);
      check(k < 4 ? "R9" : "R10", "read byte", 64'(b), 64'(exp_w[k % WIPERS]));
    end
    recv_byte(1'b0, b);
    check("R11", "after no-ack line released", 64'(b), 64'hFF);
    bus_stop();
    settle();

    // start in mid byte restarts framing
    cmp_en = 1'b0;
    bus_start();
    for (int k = 0; k < 4; k++) bit_xfer(k[0], r);
    wr_txn(7'h2D, 8'h03, 8'h42, 1'b1, "R4");
    check("R4", "wiper3 after mid-byte start", 64'(wiper_flat[31:24]), 64'h42);

    // stop before data byte writes nothing
    cmp_en = 1'b0;
    bus_start();
    send_byte(8'h5A, ack); check("R4", "address ack", 64'(ack), 64'd1);
    send_byte(8'h03, ack); check("R4", "instr ack", 64'(ack), 64'd1);
    bus_stop();
    settle();
    check("R4", "wiper3 after early stop", 64'(wiper_flat[31:24]), 64'h42);

    // repeated start switches to a read at wiper 0
    cmp_en = 1'b0;
    bus_start();
    send_byte(8'h5A, ack); check("R4", "address ack", 64'(ack), 64'd1);
    send_byte(8'h01, ack); check("R4", "instr ack", 64'(ack), 64'd1);
    bus_start();
    send_byte(8'h5B, ack); check("R4", "repeated start read ack", 64'(ack), 64'd1);
    recv_byte(1'b0, b);    check("R9", "read after repeated start", 64'(b), 64'(exp_w[0]));
    bus_stop();
    settle();

    // extra data bytes hit the same target
    cmp_en = 1'b0;
    bus_start();
    send_byte(8'h5A, ack); check("R12", "address ack", 64'(ack), 64'd1);
    send_byte(8'h00, ack); check("R12", "instr ack", 64'(ack), 64'd1);
    send_byte(8'h11, ack); check("R12", "first data ack", 64'(ack), 64'd1);
    send_byte(8'h22, ack); check("R12", "second data ack", 64'(ack), 64'd1);
    bus_stop();
    exp_w[0] = 8'h22;
    settle();
    check("R12", "wiper0 last byte wins", 64'(wiper_flat[7:0]), 64'h22);
    cmd_compare("R8");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule